// File: doc/BRIEF.md
# Prioritised Exception Dispatch Unit

This unit sits beside a processor pipeline and decides, every clock, whether an exception is taken. It gathers requests from internal sources (machine check, debug, watchdog, program/storage/translation/system-call faults, alignment, fixed-interval and programmable-interval timers) and from a set of external interrupt inputs. Each external input has its own mask bit. Input 0 is the critical interrupt pin and the others are general purpose. One request wins by fixed priority and is classed as critical or noncritical.

On a take, the unit writes a return address and the current machine state into one of two save/restore pairs: pair 0/1 for noncritical exceptions, pair 2/3 for critical ones. It then clears the relevant enable bits in its machine state register and emits a one-cycle take pulse with the exception code and its handler vector. It also carries out the two return operations. The normal return reloads the machine state from pair 0/1 and the critical return reloads it from pair 2/3. Each return presents the restored PC for one cycle.

System reset is the block's synchronous `rst` input and outranks everything. Request sources hold their request until a take pulse reports their code. All takes, returns and machine-state writes act at one clock edge and are visible on the outputs right after it.

Top module: `exc_dispatch`

## Requirements
- R1: While and after `rst`, `take`, `take_crit`, `mc_abort` and `ret` are 0, and `ms`, `ret_pc` and all four save registers are 0.
- R2: Of the qualified requests present at an edge, exactly one is taken. Codes in falling priority are machine check 1, debug 2, critical pin 3, watchdog 4, program/storage/TLB/system call 5, alignment 6, general external 7, fixed-interval timer 8, programmable-interval timer 9. `take_kind` is 0 when nothing is taken.
- R3: A take raises `take` for exactly the cycle after the sampling edge, with `take_vec` = `VEC_BASE` + code × 0x100.
- R4: Qualification rules:
  - Machine check, debug, program and alignment requests are always qualified.
  - The critical pin (`ext_irq[0]`) needs `ext_mask[0]` and CE (`ms` bit 1). The watchdog also needs CE.
  - General inputs `ext_irq[i]` (i≥1) need `ext_mask[i]` and EE (`ms` bit 0). Both timers also need EE.
- R5: Codes 1 to 4 are critical (`take_crit`=1). Codes 5 to 9 are noncritical.
- R6: On a noncritical take, `srr0` receives `cur_pc` for codes 5 (when `prog_sc`=0) and 6. For system call, external interrupts and timers it receives `nxt_pc`. `srr1` receives `ms` as it was before the take, and `srr2`/`srr3` are unchanged.
- R7: On a critical take, `srr2` receives `nxt_pc` and `srr3` the prior `ms`. `srr0`/`srr1` are unchanged.
- R8: If `mc_busy` is high when a take happens, the saved return address is `cur_pc` whatever the class, and `mc_abort` pulses with `take`.
- R9: A noncritical take clears EE. A critical take clears EE and CE. All other `ms` bits keep their values.
- R10: With no take, `rfci` loads `ms` from `srr3`, and `rfi` loads it from `srr1`; `rfci` wins if both are high. The next cycle `ret`=1 and `ret_pc` shows `srr2` or `srr0` respectively.
- R11: A take at the same edge as `rfi`/`rfci` drops the return: `ret` stays 0 and `ms` follows R9.
- R12: `ms_wr` loads `ms_wdata` into `ms` only at edges with no take and no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (system reset) |
| req_mchk | input | 1 | Machine check request |
| req_debug | input | 1 | Debug event request |
| req_wdog | input | 1 | First watchdog timeout request |
| req_prog | input | 1 | Program, data storage, TLB miss or system call request |
| prog_sc | input | 1 | Qualifies `req_prog` as a system call |
| req_align | input | 1 | Alignment fault request |
| req_fit | input | 1 | Fixed-interval timer request |
| req_pit | input | 1 | Programmable-interval timer request |
| ext_irq | input | N_EXT | External interrupt inputs; bit 0 is the critical pin |
| ext_mask | input | N_EXT | Per-input enables for `ext_irq` |
| cur_pc | input | ADDR_W | Address of the instruction in execution |
| nxt_pc | input | ADDR_W | Next sequential instruction address |
| mc_busy | input | 1 | A multicycle instruction at `cur_pc` is executing |
| rfi | input | 1 | Normal return request |
| rfci | input | 1 | Critical return request |
| ms_wr | input | 1 | Machine-state write strobe |
| ms_wdata | input | MS_W | Machine-state write data |
| take | output | 1 | One-cycle exception take pulse |
| take_crit | output | 1 | Taken exception is critical |
| take_kind | output | 4 | Code of the taken exception |
| take_vec | output | ADDR_W | Handler vector address |
| mc_abort | output | 1 | Multicycle instruction abandoned |
| ret | output | 1 | One-cycle return pulse |
| ret_pc | output | ADDR_W | Restored PC of the last return |
| ms | output | MS_W | Machine state register |
| srr0 | output | ADDR_W | Noncritical return address |
| srr1 | output | MS_W | Noncritical saved machine state |
| srr2 | output | ADDR_W | Critical return address |
| srr3 | output | MS_W | Critical saved machine state |

## Verification
The bench builds the unit with a 32-bit address, an 8-bit machine state, six external inputs and a vector base of 0x0001_0000. With only six inputs, the general-purpose set (bits 1 to 5) and the lone critical pin can each be driven in isolation or together. The 8-bit state is wide enough that random writes put values in the bits above EE and CE, so a clear that touches too many bits would be seen in `ms`, `srr1` and `srr3`. The nonzero vector base means an offset error and a missing base would give different, detectable vectors.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [3:0] {
        EXC_NONE = 4'd0,
        EXC_MCHK = 4'd1,
        EXC_DBG  = 4'd2,
        EXC_CPIN = 4'd3,
        EXC_WDOG = 4'd4,
        EXC_PROG = 4'd5,
        EXC_ALGN = 4'd6,
        EXC_EXT  = 4'd7,
        EXC_FIT  = 4'd8,
        EXC_PIT  = 4'd9
    } exc_kind_e;

    localparam int EXC_KINDS = 10;
    localparam int VEC_SHIFT = 8;
    localparam int EE_BIT    = 0;
    localparam int CE_BIT    = 1;

    typedef struct packed {
        logic      vld;
        logic      crit;
        logic      from_cur;
        exc_kind_e kind;
    } exc_sel_t;

    function automatic logic kind_is_crit(exc_kind_e k);
        return (k == EXC_MCHK) || (k == EXC_DBG) || (k == EXC_CPIN) || (k == EXC_WDOG);
    endfunction

    function automatic logic kind_faults_here(exc_kind_e k, logic sc);
        return ((k == EXC_PROG) && !sc) || (k == EXC_ALGN);
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
#(
    parameter int N_EXT = 6
) (
    input  logic             req_mchk,
    input  logic             req_debug,
    input  logic             req_wdog,
    input  logic             req_prog,
    input  logic             prog_sc,
    input  logic             req_align,
    input  logic             req_fit,
    input  logic             req_pit,
    input  logic [N_EXT-1:0] ext_irq,
    input  logic [N_EXT-1:0] ext_mask,
    input  logic             ee,
    input  logic             ce,
    input  logic             mc_busy,
    output exc_sel_t         sel
);
    logic [N_EXT-1:0]     live;
    logic [EXC_KINDS-1:0] qual;

    assign live = ext_irq & ext_mask;

    always_comb begin
        qual           = '0;
        qual[EXC_MCHK] = req_mchk;
        qual[EXC_DBG]  = req_debug;
        qual[EXC_CPIN] = live[0] & ce;
        qual[EXC_WDOG] = req_wdog & ce;
        qual[EXC_PROG] = req_prog;
        qual[EXC_ALGN] = req_align;
        qual[EXC_EXT]  = (|live[N_EXT-1:1]) & ee;
        qual[EXC_FIT]  = req_fit & ee;
        qual[EXC_PIT]  = req_pit & ee;
    end

    always_comb begin
        sel = '0;
        sel.kind = EXC_NONE;
        for (int i = EXC_KINDS - 1; i >= 1; i--) begin
            if (qual[i]) begin
                sel.vld  = 1'b1;
                sel.kind = exc_kind_e'(4'(i));
            end
        end
        sel.crit     = kind_is_crit(sel.kind);
        sel.from_cur = mc_busy || (!sel.crit && kind_faults_here(sel.kind, prog_sc));
    end
endmodule

// File: rtl/exc_srr_pair.sv
module exc_srr_pair #(
    parameter int ADDR_W = 32,
    parameter int MS_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [MS_W-1:0]   ms_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [MS_W-1:0]   ms_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ms_q   <= '0;
        end else if (cap) begin
            addr_q <= addr_in;
            ms_q   <= ms_in;
        end
    end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                MS_W     = 8,
    parameter int                N_EXT    = 6,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_mchk,
    input  logic              req_debug,
    input  logic              req_wdog,
    input  logic              req_prog,
    input  logic              prog_sc,
    input  logic              req_align,
    input  logic              req_fit,
    input  logic              req_pit,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic [N_EXT-1:0]  ext_mask,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] nxt_pc,
    input  logic              mc_busy,
    input  logic              rfi,
    input  logic              rfci,
    input  logic              ms_wr,
    input  logic [MS_W-1:0]   ms_wdata,
    output logic              take,
    output logic              take_crit,
    output logic [3:0]        take_kind,
    output logic [ADDR_W-1:0] take_vec,
    output logic              mc_abort,
    output logic              ret,
    output logic [ADDR_W-1:0] ret_pc,
    output logic [MS_W-1:0]   ms,
    output logic [ADDR_W-1:0] srr0,
    output logic [MS_W-1:0]   srr1,
    output logic [ADDR_W-1:0] srr2,
    output logic [MS_W-1:0]   srr3
);
    localparam int PAIRS = 2;
    localparam logic [MS_W-1:0] EE_M = MS_W'(1) << EE_BIT;
    localparam logic [MS_W-1:0] CE_M = MS_W'(1) << CE_BIT;

    exc_sel_t          sel;
    logic [ADDR_W-1:0] save_addr;
    logic [ADDR_W-1:0] pair_addr [PAIRS];
    logic [MS_W-1:0]   pair_ms   [PAIRS];

    exc_prio #(.N_EXT(N_EXT)) u_prio (
        .req_mchk (req_mchk),
        .req_debug(req_debug),
        .req_wdog (req_wdog),
        .req_prog (req_prog),
        .prog_sc  (prog_sc),
        .req_align(req_align),
        .req_fit  (req_fit),
        .req_pit  (req_pit),
        .ext_irq  (ext_irq),
        .ext_mask (ext_mask),
        .ee       (ms[EE_BIT]),
        .ce       (ms[CE_BIT]),
        .mc_busy  (mc_busy),
        .sel      (sel)
    );

    assign save_addr = sel.from_cur ? cur_pc : nxt_pc;

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        exc_srr_pair #(.ADDR_W(ADDR_W), .MS_W(MS_W)) u_pair (
            .clk    (clk),
            .rst    (rst),
            .cap    (sel.vld && (sel.crit == (g == 1))),
            .addr_in(save_addr),
            .ms_in  (ms),
            .addr_q (pair_addr[g]),
            .ms_q   (pair_ms[g])
        );
    end

    assign srr0 = pair_addr[0];
    assign srr1 = pair_ms[0];
    assign srr2 = pair_addr[1];
    assign srr3 = pair_ms[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            take      <= 1'b0;
            take_crit <= 1'b0;
            take_kind <= 4'd0;
            take_vec  <= '0;
            mc_abort  <= 1'b0;
            ret       <= 1'b0;
            ret_pc    <= '0;
            ms        <= '0;
        end else begin
            take      <= sel.vld;
            take_crit <= sel.vld && sel.crit;
            take_kind <= sel.kind;
            take_vec  <= VEC_BASE + (ADDR_W'(sel.kind) << VEC_SHIFT);
            mc_abort  <= sel.vld && mc_busy;
            ret       <= 1'b0;
            if (sel.vld) begin
                ms <= ms & ~(sel.crit ? (EE_M | CE_M) : EE_M);
            end else if (rfci) begin
                ms     <= pair_ms[1];
                ret_pc <= pair_addr[1];
                ret    <= 1'b1;
            end else if (rfi) begin
                ms     <= pair_ms[0];
                ret_pc <= pair_addr[0];
                ret    <= 1'b1;
            end else if (ms_wr) begin
                ms <= ms_wdata;
            end
        end
    end

    assert_take_ret_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(take && ret));
    assert_crit_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (take && take_crit) |-> (!ms[EE_BIT] && !ms[CE_BIT]));
    assert_noncrit_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (take && !take_crit) |-> !ms[EE_BIT]);
    assert_crit_keeps_pair0_R7: assert property (@(posedge clk) disable iff (rst)
        (take && take_crit) |-> ($stable(srr0) && $stable(srr1)));
    assert_noncrit_keeps_pair1_R6: assert property (@(posedge clk) disable iff (rst)
        (take && !take_crit) |-> ($stable(srr2) && $stable(srr3)));
    assert_ext_needs_ee_R4: assert property (@(posedge clk) disable iff (rst)
        (take && take_kind == 4'(EXC_EXT)) |-> srr1[EE_BIT]);
    assert_abort_with_take_R8: assert property (@(posedge clk) disable iff (rst)
        mc_abort |-> take);
    assert_take_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        take |-> (take_kind != 4'd0));
endmodule

// File: tb/exc_dispatch_tb.sv
module exc_dispatch_tb;
    localparam int AW = 32;
    localparam int MW = 8;
    localparam int NE = 6;
    localparam logic [AW-1:0] VB = 32'h0001_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_mchk, req_debug, req_wdog, req_prog, prog_sc, req_align, req_fit, req_pit;
    logic [NE-1:0] ext_irq, ext_mask;
    logic [AW-1:0] cur_pc, nxt_pc;
    logic mc_busy, rfi, rfci, ms_wr;
    logic [MW-1:0] ms_wdata;
    logic take, take_crit, mc_abort, ret;
    logic [3:0] take_kind;
    logic [AW-1:0] take_vec, ret_pc, srr0, srr2;
    logic [MW-1:0] ms, srr1, srr3;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [MW-1:0] m_ms, m_s1, m_s3;
    logic [AW-1:0] m_s0, m_s2, m_rpc, e_vec;
    logic [3:0] e_kind;
    logic e_take, e_crit, e_abort, e_ret;

    always #10 clk = ~clk;

    exc_dispatch #(.ADDR_W(AW), .MS_W(MW), .N_EXT(NE), .VEC_BASE(VB)) u_dut (
        .clk(clk), .rst(rst), .req_mchk(req_mchk), .req_debug(req_debug),
        .req_wdog(req_wdog), .req_prog(req_prog), .prog_sc(prog_sc),
        .req_align(req_align), .req_fit(req_fit), .req_pit(req_pit),
        .ext_irq(ext_irq), .ext_mask(ext_mask), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
        .mc_busy(mc_busy), .rfi(rfi), .rfci(rfci), .ms_wr(ms_wr), .ms_wdata(ms_wdata),
        .take(take), .take_crit(take_crit), .take_kind(take_kind), .take_vec(take_vec),
        .mc_abort(mc_abort), .ret(ret), .ret_pc(ret_pc), .ms(ms),
        .srr0(srr0), .srr1(srr1), .srr2(srr2), .srr3(srr3)
    );

    task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {req_mchk, req_debug, req_wdog, req_prog, prog_sc, req_align, req_fit, req_pit} = '0;
        ext_irq = '0; ext_mask = '0; mc_busy = 0; rfi = 0; rfci = 0; ms_wr = 0;
        ms_wdata = '0; cur_pc = 32'h100; nxt_pc = 32'h104;
    endtask

    // Independent model of one edge, from the requirements.
    task automatic model();
        logic ee, ce, crit;
        logic [AW-1:0] ra;
        ee = m_ms[0]; ce = m_ms[1];
        if (req_mchk) e_kind = 1;
        else if (req_debug) e_kind = 2;
        else if (ext_irq[0] && ext_mask[0] && ce) e_kind = 3;
        else if (req_wdog && ce) e_kind = 4;
        else if (req_prog) e_kind = 5;
        else if (req_align) e_kind = 6;
        else if (ee && |(ext_irq[NE-1:1] & ext_mask[NE-1:1])) e_kind = 7;
        else if (req_fit && ee) e_kind = 8;
        else if (req_pit && ee) e_kind = 9;
        else e_kind = 0;
        e_take = (e_kind != 0);
        crit = e_take && (e_kind <= 4);
        e_crit = crit;
        e_vec = VB + 32'(e_kind) * 32'h100;
        e_abort = e_take && mc_busy;
        e_ret = 0;
        if (mc_busy) ra = cur_pc;
        else if (!crit && ((e_kind == 5 && !prog_sc) || e_kind == 6)) ra = cur_pc;
        else ra = nxt_pc;
        if (e_take) begin
            if (crit) begin m_s2 = ra; m_s3 = m_ms; m_ms = m_ms & 8'hFC; end
            else begin m_s0 = ra; m_s1 = m_ms; m_ms = m_ms & 8'hFE; end
        end else if (rfci) begin m_ms = m_s3; m_rpc = m_s2; e_ret = 1; end
        else if (rfi) begin m_ms = m_s1; m_rpc = m_s0; e_ret = 1; end
        else if (ms_wr) m_ms = ms_wdata;
    endtask

    task automatic step();
        model();
        @(negedge clk);
        cycles++;
        chk("R3 take", 32'(take), 32'(e_take));
        chk("R2 kind", 32'(take_kind), 32'(e_kind));
        if (e_take) chk("R3 vec", take_vec, e_vec);
        chk("R5 crit", 32'(take_crit), 32'(e_crit));
        chk("R8 abort", 32'(mc_abort), 32'(e_abort));
        chk("R10 ret", 32'(ret), 32'(e_ret));
        chk("R10 ret_pc", ret_pc, m_rpc);
        chk("R9 ms", 32'(ms), 32'(m_ms));
        chk("R6 srr0", srr0, m_s0);
        chk("R6 srr1", 32'(srr1), 32'(m_s1));
        chk("R7 srr2", srr2, m_s2);
        chk("R7 srr3", 32'(srr3), 32'(m_s3));
    endtask

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        idle();
        m_ms = 0; m_s1 = 0; m_s3 = 0; m_s0 = 0; m_s2 = 0; m_rpc = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 take", 32'(take), 0);
        chk("R1 ret", 32'(ret), 0);
        chk("R1 ms", 32'(ms), 0);
        chk("R1 srr", srr0 | srr2 | 32'(srr1) | 32'(srr3) | ret_pc, 0);
        rst = 0;

        // R4: general input blocked while EE=0
        ext_irq = 6'b000010; ext_mask = '1; step();
        chk("R4 ee off", 32'(take), 0);
        ext_irq = '0; ms_wr = 1; ms_wdata = 8'h03; step();
        ms_wr = 0; ext_irq = 6'b000010; ext_mask = 6'b111101; step();
        chk("R4 masked", 32'(take), 0);
        ext_mask = '1; cur_pc = 32'h200; nxt_pc = 32'h204; step();
        chk("R4 ext taken", 32'(take_kind), 7);
        chk("R6 async next", srr0, 32'h204);
        ext_irq = 6'b000001; step();
        chk("R4 crit pin", 32'(take_kind), 3);
        chk("R9 both cleared", 32'(ms), 0);
        // R4: critical pin blocked while CE=0
        step();
        chk("R4 ce off", 32'(take), 0);

        // R11 / R12: take beats return and write
        ext_irq = '0; ms_wr = 1; ms_wdata = 8'h03; step();
        ms_wr = 1; ms_wdata = 8'hF0; req_align = 1; rfi = 1; cur_pc = 32'h300; step();
        chk("R11 ret dropped", 32'(ret), 0);
        chk("R12 write lost", 32'(ms), 32'h02);
        chk("R6 align here", srr0, 32'h300);
        idle(); rfi = 1; step();
        chk("R10 rfi", ret_pc, 32'h300);
        chk("R10 ms restore", 32'(ms), 32'h03);

        // R2: everything at once, machine check wins
        idle(); {req_mchk, req_debug, req_wdog, req_prog, req_align, req_fit, req_pit} = '1;
        ext_irq = '1; ext_mask = '1; mc_busy = 1; cur_pc = 32'h400; step();
        chk("R2 top", 32'(take_kind), 1);
        chk("R8 cur saved", srr2, 32'h400);
        idle(); rfci = 1; rfi = 1; step();
        chk("R10 rfci wins", ret_pc, 32'h400);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            idle();
            req_mchk  = ($urandom % 40) == 0;
            req_debug = ($urandom % 30) == 0;
            req_wdog  = ($urandom % 12) == 0;
            req_prog  = ($urandom % 10) == 0;
            prog_sc   = $urandom % 2;
            req_align = ($urandom % 10) == 0;
            req_fit   = ($urandom % 8) == 0;
            req_pit   = ($urandom % 8) == 0;
            ext_irq   = NE'($urandom) & NE'($urandom);
            ext_mask  = NE'($urandom);
            cur_pc    = $urandom & 32'hFFFF_FFFC;
            nxt_pc    = cur_pc + 4;
            mc_busy   = ($urandom % 4) == 0;
            rfi       = ($urandom % 6) == 0;
            rfci      = ($urandom % 8) == 0;
            ms_wr     = ($urandom % 4) == 0;
            ms_wdata  = MW'($urandom);
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule